// File: doc/BRIEF.md
# Sequential Sign-Magnitude Shift-Add Multiplier

This block multiplies two signed 16-bit operands over several clock cycles and returns a signed 32-bit product. On acceptance each operand is split into a sign bit and a magnitude. The two magnitudes are multiplied as unsigned numbers, one conditional add per multiplier bit. The product sign is the exclusive-or of the two operand signs. To save logic, both conversions between signed and sign-magnitude form use plain bitwise inversion with no increment. A negative value therefore carries a magnitude one below its true size, and a product with negative sign is off by up to a small bounded amount. Products of non-negative operands are exact.

The input side is a request with an implicit ready. `start` together with the operands is taken on a rising edge only while `busy` is low. While `busy` is high the operand inputs are ignored, so `busy` acts as inverted ready. The output side has no back-pressure. `done` pulses for exactly one cycle, and `product` keeps its value until the next operation completes. With `early_en` high at acceptance, the operation stops as soon as no set multiplier bits remain. Latency then depends on the data but never exceeds the fixed 16 steps.

Top module: `sm_shift_mult`

## Requirements
- R1: After reset `busy` is 0, `done` is 0 and `product` is 0.
- R2: A rising edge with `start` high and `busy` low accepts `op_a`, `op_b` and `early_en`, and `busy` is high in the following cycle.
- R3: `start`, `op_a` and `op_b` have no effect while `busy` is high: the result and the latency belong to the operation already accepted.
- R4: With `early_en` low at acceptance, `done` is high in the 16th cycle after the accepting edge, and `busy` is high in every cycle between.
- R5: `done` is high for exactly one cycle, `busy` is low whenever `done` is high, and `product` changes only on the edge that raises `done`.
- R6: The magnitude of a negative operand x (bit 15 set) is the bitwise inverse of x, for example 0xFFFF gives 0 and 0x8000 gives 0x7FFF. A non-negative operand is its own magnitude.
- R7: Let m be the 32-bit unsigned product of the two magnitudes, and let s be the exclusive-or of bit 15 of the two operands. `product` is the bitwise inverse of m when s is 1, and m otherwise.
- R8: When both operands are non-negative, `product` equals the exact product.
- R9: Taking `product` as signed, it differs from the exact signed product by at most |op_a| + |op_b|.
- R10: With `early_en` high at acceptance, the latency in cycles equals one plus the index of the highest set bit of op_b's magnitude (R6). The latency is 1 when that magnitude is zero.
- R11: The result with `early_en` high equals the result for the same operands with `early_en` low.
- R12: Changing `early_en` while `busy` is high does not change the latency or the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request; taken when busy is low |
| early_en | input | 1 | Stop once the remaining multiplier bits are zero |
| op_a | input | 16 | Multiplicand, two's complement |
| op_b | input | 16 | Multiplier, two's complement |
| busy | output | 1 | Operation in progress; inputs ignored |
| done | output | 1 | One-cycle pulse: product valid |
| product | output | 32 | Two's complement product, held until the next completion |

## Verification
The hardest case to reach from the ports is a new request, together with a flipped stop mode, arriving while an operation is still in progress. The bench reaches it by raising `start` with different operands and toggling `early_en` in the cycle right after acceptance. It keeps them that way until completion, then checks that the latency and the product still match the accepted request. Every operation is timed cycle by cycle in both modes. The sweep includes 0x8000, 0xFFFF and operands whose magnitude conversion ends in zero, because those values show the conversion error most clearly.

// File: rtl/sm_mult_pkg.sv
package sm_mult_pkg;
  localparam int unsigned OP_W  = 16;
  localparam int unsigned PROD_W = 2 * OP_W;
endpackage

// File: rtl/sm_split.sv
// Two's complement to sign-magnitude by inversion only (no +1).
module sm_split #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] tc_in,
  output logic         sign_out,
  output logic [W-1:0] mag_out
);
  always_comb begin
    sign_out = tc_in[W-1];
    mag_out  = tc_in[W-1] ? ~tc_in : tc_in;
  end
endmodule

// File: rtl/sm_join.sv
// Sign-magnitude to two's complement by inversion only (no +1).
module sm_join #(
  parameter int unsigned W = 32
) (
  input  logic         sign_in,
  input  logic [W-1:0] mag_in,
  output logic [W-1:0] tc_out
);
  always_comb tc_out = sign_in ? ~mag_in : mag_in;
endmodule

// File: rtl/sa_step.sv
// One conditional shift-add step of the unsigned magnitude product.
module sa_step #(
  parameter int unsigned W = 16,
  localparam int unsigned PW = 2 * W
) (
  input  logic [PW-1:0] acc_in,
  input  logic [PW-1:0] mcand_in,
  input  logic [W-1:0]  mplier_in,
  output logic [PW-1:0] acc_out,
  output logic [PW-1:0] mcand_out,
  output logic [W-1:0]  mplier_out,
  output logic          rest_zero
);
  always_comb begin
    acc_out    = mplier_in[0] ? acc_in + mcand_in : acc_in;
    mcand_out  = mcand_in << 1;
    mplier_out = mplier_in >> 1;
    rest_zero  = (mplier_out == '0);
  end
endmodule

// File: rtl/sm_shift_mult.sv
module sm_shift_mult
  import sm_mult_pkg::*;
#(
  parameter int unsigned W = OP_W,
  localparam int unsigned PW = 2 * W,
  localparam int unsigned CW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          early_en,
  input  logic [W-1:0]  op_a,
  input  logic [W-1:0]  op_b,
  output logic          busy,
  output logic          done,
  output logic [PW-1:0] product
);
  localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

  logic          sign_a, sign_b;
  logic [W-1:0]  mag_a, mag_b;
  logic [PW-1:0] acc_q, mcand_q, acc_nx, mcand_nx, prod_tc;
  logic [W-1:0]  mplier_q, mplier_nx;
  logic [CW-1:0] cnt_q;
  logic          neg_q, early_q, rest_zero, last_step, accept;

  sm_split #(.W(W)) u_split_a (.tc_in(op_a), .sign_out(sign_a), .mag_out(mag_a));
  sm_split #(.W(W)) u_split_b (.tc_in(op_b), .sign_out(sign_b), .mag_out(mag_b));

  sa_step #(.W(W)) u_step (
    .acc_in(acc_q), .mcand_in(mcand_q), .mplier_in(mplier_q),
    .acc_out(acc_nx), .mcand_out(mcand_nx), .mplier_out(mplier_nx),
    .rest_zero(rest_zero)
  );

  sm_join #(.W(PW)) u_join (.sign_in(neg_q), .mag_in(acc_nx), .tc_out(prod_tc));

  assign accept    = start && !busy;
  assign last_step = (cnt_q == LAST_STEP) || (early_q && rest_zero);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      product  <= '0;
      acc_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
      cnt_q    <= '0;
      neg_q    <= 1'b0;
      early_q  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy     <= 1'b1;
        acc_q    <= '0;
        mcand_q  <= {{W{1'b0}}, mag_a};
        mplier_q <= mag_b;
        cnt_q    <= '0;
        neg_q    <= sign_a ^ sign_b;
        early_q  <= early_en;
      end else if (busy) begin
        acc_q    <= acc_nx;
        mcand_q  <= mcand_nx;
        mplier_q <= mplier_nx;
        cnt_q    <= cnt_q + 1'b1;
        if (last_step) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          product <= prod_tc;
        end
      end
    end
  end

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R5
  product_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(product));

  // R4
  fixed_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !early_q) |-> ($past(cnt_q) == LAST_STEP));

  // R10
  early_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && early_q) |-> ($past(mplier_q[W-1:1]) == '0));
endmodule

// File: tb/sm_shift_mult_bench.sv
`timescale 1ns/1ps
module sm_shift_mult_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        early_en = 1'b0;
  logic [15:0] op_a = '0;
  logic [15:0] op_b = '0;
  logic        busy, done;
  logic [31:0] product;

  int n_checks = 0;
  int n_errors = 0;

  always #2.5 clk = ~clk;

  sm_shift_mult u_sm_shift_mult (
    .clk(clk), .rst_n(rst_n), .start(start), .early_en(early_en),
    .op_a(op_a), .op_b(op_b), .busy(busy), .done(done), .product(product)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  function automatic logic [15:0] magf(input logic [15:0] x);
    return x[15] ? ~x : x;
  endfunction

  function automatic logic [31:0] expf(input logic [15:0] a, input logic [15:0] b);
    logic [31:0] m;
    m = {16'b0, magf(a)} * {16'b0, magf(b)};
    return (a[15] ^ b[15]) ? ~m : m;
  endfunction

  function automatic int early_lat(input logic [15:0] b);
    logic [15:0] m;
    int l;
    m = magf(b);
    l = 1;
    for (int k = 0; k < 16; k++) if (m[k]) l = k + 1;
    return l;
  endfunction

  function automatic logic [15:0] pick(input int i);
    case (i)
      0: return 16'h0000;  1: return 16'h0001;  2: return 16'h0002;
      3: return 16'h0003;  4: return 16'hFFFF;  5: return 16'hFFFE;
      6: return 16'h7FFF;  7: return 16'h8000;  8: return 16'h8001;
      9: return 16'h4000; 10: return 16'h00FF; 11: return 16'hFF00;
      default: return 16'(i * 12071 + i * i * 37);
    endcase
  endfunction

  task automatic run_op(input logic [15:0] a, input logic [15:0] b, input logic em,
                        input bit poke, output int lat, output logic [31:0] res);
    @(negedge clk);
    op_a = a; op_b = b; early_en = em; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R2 busy after accept", longint'(busy), 1);
    if (poke) begin
      start = 1'b1; op_a = ~a; op_b = b ^ 16'h5A5A; early_en = !em;
    end
    lat = 0;
    forever begin
      @(negedge clk);
      lat++;
      if (done === 1'b1 || lat > 40) break;
      if (!em) check(busy === 1'b1, "R4 busy during run", longint'(busy), 1);
    end
    start = 1'b0; early_en = 1'b0;
    res = product;
    @(negedge clk);
    check(done === 1'b0, "R5 done one cycle", longint'(done), 0);
    check(product === res, "R5 product hold", longint'(product), longint'(res));
  endtask

  task automatic verify(input logic [15:0] a, input logic [15:0] b, input logic [31:0] res);
    longint ex, r, d, bound;
    check(res === expf(a, b), "R7 R6 product formula", longint'(res), longint'(expf(a, b)));
    ex = longint'($signed(a)) * longint'($signed(b));
    r  = longint'($signed(res));
    d  = (r > ex) ? r - ex : ex - r;
    bound = (longint'($signed(a)) < 0 ? -longint'($signed(a)) : longint'($signed(a))) +
            (longint'($signed(b)) < 0 ? -longint'($signed(b)) : longint'($signed(b)));
    check(d <= bound, "R9 error bound", d, bound);
    if (!a[15] && !b[15]) check(r == ex, "R8 exact non-negative", r, ex);
  endtask

  initial begin
    #(190000 * 5);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    int lat;
    logic [31:0] res, res2;
    repeat (3) @(negedge clk);
    check(busy === 1'b0, "R1 reset busy", longint'(busy), 0);
    check(done === 1'b0, "R1 reset done", longint'(done), 0);
    check(product === 32'd0, "R1 reset product", longint'(product), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(product === 32'd0 && busy === 1'b0, "R1 after release", longint'(product), 0);

    // R6 direct: 0x8000 * 1 -> magnitude 0x7FFF, negative sign -> ~0x00007FFF
    run_op(16'h8000, 16'h0001, 1'b0, 1'b0, lat, res);
    check(res === 32'hFFFF8000, "R6 magnitude of 0x8000", longint'(res), 32'hFFFF8000);
    // R6 direct: 0xFFFF * 5 -> magnitude 0, sign negative -> 0xFFFFFFFF
    run_op(16'hFFFF, 16'h0005, 1'b0, 1'b0, lat, res);
    check(res === 32'hFFFFFFFF, "R6 magnitude of 0xFFFF", longint'(res), 32'hFFFFFFFF);

    // R4 R7 R8 R9: fixed-latency sweep
    for (int i = 0; i < 48; i++) begin
      for (int j = 0; j < 48; j++) begin
        run_op(pick(i), pick(j), 1'b0, 1'b0, lat, res);
        check(lat == 16, "R4 fixed latency", lat, 16);
        verify(pick(i), pick(j), res);
      end
    end

    // R10 R11: early-stop sweep
    for (int i = 0; i < 48; i++) begin
      for (int j = 0; j < 48; j++) begin
        run_op(pick(i), pick(j), 1'b1, 1'b0, lat, res);
        check(lat == early_lat(pick(j)), "R10 early latency", lat, early_lat(pick(j)));
        check(res === expf(pick(i), pick(j)), "R11 early result", longint'(res),
              longint'(expf(pick(i), pick(j))));
      end
    end

    // R3 R12: requests and mode flips while busy
    for (int i = 0; i < 24; i++) begin
      run_op(pick(i + 5), pick(i * 2), 1'b0, 1'b1, lat, res);
      check(lat == 16, "R12 R3 fixed latency under poke", lat, 16);
      check(res === expf(pick(i + 5), pick(i * 2)), "R3 result under poke", longint'(res),
            longint'(expf(pick(i + 5), pick(i * 2))));
      run_op(pick(i + 5), pick(i * 2), 1'b1, 1'b1, lat, res2);
      check(lat == early_lat(pick(i * 2)), "R12 R3 early latency under poke", lat,
            early_lat(pick(i * 2)));
      check(res2 === res, "R12 early result under poke", longint'(res2), longint'(res));
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule